// File: doc/BRIEF.md
# Serial Converter Output Shifter

This block is the device end of a three-wire serial link for a 12-bit converter. A host pulls an active-low select line and toggles a serial clock. The block latches a parallel sample word when select falls. It then returns that word on a single data line with an output-enable, so a pad can tri-state it. Each frame starts with two zero bits, then carries the twelve sample bits most significant first. In a sixteen-clock frame, two zero bits follow the data. The line is released on the sixteenth falling clock edge, or when select rises.

Select and the serial clock come from the host and are asynchronous to the block. Both pass through synchronizer chains in the block's system clock domain, and all edges are detected from the synchronized levels. A track/hold status output goes to hold at the start of a frame. It returns to track once the conversion window of fourteen clocks is nearly over. If select is released before that window ends, the block raises an abort flag. A completed frame produces a one-cycle done pulse.

Top module: `adc_serial_tx`

## Requirements
- R1: While reset is asserted and after it, with select high: `sdata_oe`=0, `sdata_out`=0, `track_o`=1, `frame_done`=0, `aborted`=0.
- R2: A select falling edge enables the line (`sdata_oe`=1) with the first leading zero on `sdata_out` and puts `track_o` to 0 (hold).
- R3: After the first serial-clock falling edge of a frame, `sdata_out` carries the second leading zero.
- R4: After falling edge k of a frame (2 ≤ k ≤ 13), `sdata_out` equals bit 13−k of the latched 12-bit word, giving bit 11 first and bit 0 last.
- R5: The word on `sample_in` is captured at the select falling edge; changes to `sample_in` during the frame do not change the bits shifted out.
- R6: `track_o` stays 0 through the 13th falling edge and returns to 1 on the following serial-clock rising edge.
- R7: A select rise after fewer than 14 falling edges drops `sdata_oe`, sets `aborted`=1 and `track_o`=1, and gives no `frame_done` pulse.
- R8: Falling edges 14 and 15 drive zero. The 16th falling edge drops `sdata_oe` and gives exactly one `frame_done` pulse of one system clock.
- R9: A select rise after 14 or 15 falling edges drops `sdata_oe` and gives one `frame_done` pulse, with `aborted` left at 0.
- R10: With select high, serial-clock edges are ignored: `sdata_oe` and `sdata_out` stay 0, and the next frame starts again from the first leading zero. The data line reads 0 whenever it is disabled.
- R11: The next select falling edge clears `aborted` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the host (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| sample_in | input | 12 | Parallel sample word |
| sdata_out | output | 1 | Serial data value (0 when disabled) |
| sdata_oe | output | 1 | Output enable for the data pad; 0 means high impedance |
| track_o | output | 1 | 1 = track, 0 = hold |
| frame_done | output | 1 | One-cycle pulse when a frame ends normally |
| aborted | output | 1 | Set when a frame is cut short; cleared on the next frame |

## Verification
The bench builds the block with its default parameters: a 12-bit word, two leading zeros, a sixteen-slot frame and two synchronizer stages. It holds each host pin level for six system clocks, which is longer than the synchronizer latency plus the edge register, so every frame length from zero to sixteen falling edges can be reached. The vector table covers the abort boundary on both sides (13 against 14 edges), both normal endings, and the extreme words all-zero, all-one and alternating. This makes every bit position and both trailing slots observable.

// File: rtl/adc_tx_pkg.sv
`timescale 1ns/1ps
package adc_tx_pkg;

  // How the frame controller decided to close the current frame.
  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_FULL  = 2'd1,  // last slot consumed by a falling edge
    END_SHORT = 2'd2,  // select released after the conversion window
    END_ABORT = 2'd3   // select released inside the conversion window
  } frame_end_e;

  // A release is an abort while fewer falling edges than the
  // conversion window have been seen.
  function automatic logic release_is_abort(input int unsigned falls,
                                            input int unsigned conv_slots);
    return falls < conv_slots;
  endfunction

  // Track mode resumes once this many falling edges have passed.
  function automatic int unsigned track_resume_slot(input int unsigned conv_slots);
    return conv_slots - 1;
  endfunction

endpackage

// File: rtl/adc_pin_sync.sv
`timescale 1ns/1ps
module adc_pin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/adc_frame_shifter.sv
`timescale 1ns/1ps
module adc_frame_shifter #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned LEAD_ZEROS  = 2,
  parameter int unsigned FRAME_SLOTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              head_o
);

  localparam int unsigned TRAIL_ZEROS = FRAME_SLOTS - LEAD_ZEROS - DATA_W;

  // Lay the word into a full frame image: zeros, word (MSB first), zeros.
  function automatic logic [FRAME_SLOTS-1:0] frame_image(input logic [DATA_W-1:0] w);
    logic [FRAME_SLOTS-1:0] img;
    img = '0;
    for (int i = 0; i < DATA_W; i++) begin
      img[TRAIL_ZEROS + i] = w[i];
    end
    return img;
  endfunction

  logic [FRAME_SLOTS-1:0] frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (load_i) begin
      frame_q <= frame_image(word_i);
    end else if (shift_i) begin
      frame_q <= {frame_q[FRAME_SLOTS-2:0], 1'b0};
    end
  end

  assign head_o = frame_q[FRAME_SLOTS-1];

endmodule

// File: rtl/adc_frame_ctrl.sv
`timescale 1ns/1ps
module adc_frame_ctrl
  import adc_tx_pkg::*;
#(
  parameter int unsigned CONV_SLOTS  = 14,
  parameter int unsigned FRAME_SLOTS = 16,
  parameter int unsigned SLOT_W      = $clog2(FRAME_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sclk_rise_i,
  output logic              load_o,
  output logic              shift_o,
  output logic              active_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              track_o,
  output logic              aborted_o,
  output logic              done_o,
  output frame_end_e        end_kind_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [SLOT_W-1:0] TRACK_SLOT = SLOT_W'(track_resume_slot(CONV_SLOTS));

  logic              active_q, track_q, aborted_q, done_q;
  logic [SLOT_W-1:0] slot_q;
  frame_end_e        end_kind;

  always_comb begin
    end_kind = END_NONE;
    if (active_q) begin
      if (cs_rise_i) begin
        end_kind = release_is_abort(int'(slot_q), CONV_SLOTS) ? END_ABORT : END_SHORT;
      end else if (sclk_fall_i && slot_q == LAST_SLOT) begin
        end_kind = END_FULL;
      end
    end
  end

  assign load_o  = cs_fall_i;
  assign shift_o = active_q && sclk_fall_i && (end_kind == END_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      slot_q    <= '0;
      track_q   <= 1'b1;
      aborted_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (load_o) begin
      active_q  <= 1'b1;
      slot_q    <= '0;
      track_q   <= 1'b0;
      aborted_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (end_kind)
        END_ABORT: begin
          active_q  <= 1'b0;
          aborted_q <= 1'b1;
          track_q   <= 1'b1;
        end
        END_SHORT, END_FULL: begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
        default: begin
          if (shift_o) begin
            slot_q <= slot_q + 1'b1;
          end
          if (active_q && sclk_rise_i && slot_q == TRACK_SLOT) begin
            track_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign active_o   = active_q;
  assign slot_o     = slot_q;
  assign track_o    = track_q;
  assign aborted_o  = aborted_q;
  assign done_o     = done_q;
  assign end_kind_o = end_kind;

endmodule

// File: rtl/adc_serial_tx.sv
`timescale 1ns/1ps
module adc_serial_tx
  import adc_tx_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned LEAD_ZEROS  = 2,
  parameter int unsigned FRAME_SLOTS = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic              track_o,
  output logic              frame_done,
  output logic              aborted
);

  localparam int unsigned CONV_SLOTS = LEAD_ZEROS + DATA_W;
  localparam int unsigned SLOT_W     = $clog2(FRAME_SLOTS);
  localparam int unsigned NUM_PINS   = 2;
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 2'b11;  // both pins idle high

  // Pin 0 = select, pin 1 = serial clock.
  logic [NUM_PINS-1:0] pin_raw, pin_level, pin_rise, pin_fall;
  assign pin_raw = {sclk, cs_n};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_sync
    adc_pin_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_IDLE[g])
    ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_raw[g]),
      .level_o(pin_level[g]),
      .rise_o (pin_rise[g]),
      .fall_o (pin_fall[g])
    );
  end

  // Named internal events, visible to the bound checker.
  logic cs_fall_w, cs_rise_w, sclk_fall_w, sclk_rise_w;
  assign cs_fall_w   = pin_fall[0];
  assign cs_rise_w   = pin_rise[0];
  assign sclk_fall_w = pin_fall[1];
  assign sclk_rise_w = pin_rise[1];

  logic              load_w, shift_w, active_w, head_w;
  logic [SLOT_W-1:0] slot_w;
  frame_end_e        end_kind_w;

  adc_frame_ctrl #(
    .CONV_SLOTS (CONV_SLOTS),
    .FRAME_SLOTS(FRAME_SLOTS),
    .SLOT_W     (SLOT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_fall_i  (cs_fall_w),
    .cs_rise_i  (cs_rise_w),
    .sclk_fall_i(sclk_fall_w),
    .sclk_rise_i(sclk_rise_w),
    .load_o     (load_w),
    .shift_o    (shift_w),
    .active_o   (active_w),
    .slot_o     (slot_w),
    .track_o    (track_o),
    .aborted_o  (aborted),
    .done_o     (frame_done),
    .end_kind_o (end_kind_w)
  );

  adc_frame_shifter #(
    .DATA_W     (DATA_W),
    .LEAD_ZEROS (LEAD_ZEROS),
    .FRAME_SLOTS(FRAME_SLOTS)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .shift_i(shift_w),
    .word_i (sample_in),
    .head_o (head_w)
  );

  assign sdata_oe  = active_w;
  assign sdata_out = active_w & head_w;

endmodule

// File: rtl/adc_serial_tx_chk.sv
`timescale 1ns/1ps
module adc_serial_tx_chk #(
  parameter int unsigned SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_fall,
  input logic              sclk_rise,
  input logic              sdata_oe,
  input logic              sdata_out,
  input logic              track_o,
  input logic              frame_done,
  input logic              aborted,
  input logic [SLOT_W-1:0] slot
);

  assert_lead_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdata_oe && !sdata_out && !track_o));

  assert_track_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_o) |-> ($past(sclk_rise) || aborted));

  assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aborted) |-> (!sdata_oe && track_o && !frame_done));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!sdata_oe && !aborted));

  assert_park_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata_out);

  assert_idle_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdata_oe && !cs_fall) |=> $stable(slot));

  assert_abort_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !aborted);

endmodule

bind adc_serial_tx adc_serial_tx_chk #(
  .SLOT_W(SLOT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_fall   (cs_fall_w),
  .sclk_rise (sclk_rise_w),
  .sdata_oe  (sdata_oe),
  .sdata_out (sdata_out),
  .track_o   (track_o),
  .frame_done(frame_done),
  .aborted   (aborted),
  .slot      (slot_w)
);

// File: tb/sim_adc_serial_tx.sv
`timescale 1ns/1ps
module sim_adc_serial_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sample_in = '0;
  logic        sdata_out, sdata_oe, track_o, frame_done, aborted;

  int n_cmp = 0;
  int n_bad = 0;
  int done_seen = 0;
  bit summary_done = 1'b0;
  bit scramble = 1'b0;

  initial forever #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) if (frame_done) done_seen++;

  adc_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample_in(sample_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
    .track_o(track_o), .frame_done(frame_done), .aborted(aborted)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Hold a pin level long enough for synchronizers, then sample off-edge.
  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  // Expected data line after k falling edges, written from the slot rule.
  function automatic int want_bit(input logic [11:0] w, input int k);
    if (k >= 2 && k <= 13) return int'(w[13 - k]);
    return 0;
  endfunction

  task automatic run_frame(input logic [11:0] w, input int nfall,
                           input bit exp_abort, input bit exp_done);
    int d0;
    d0 = done_seen;
    sample_in = w;
    cs_n = 1'b0;
    settle();
    chk("R2 oe at select fall", int'(sdata_oe), 1);
    chk("R2 first leading zero", int'(sdata_out), 0);
    chk("R2 hold", int'(track_o), 0);
    if (scramble) sample_in = ~w;
    for (int k = 1; k <= nfall; k++) begin
      sclk = 1'b0;
      settle();
      if (k == 1)       chk("R3 second leading zero", int'(sdata_out), 0);
      else if (k <= 13) chk(scramble ? "R5 latched bit" : "R4 data bit", int'(sdata_out), want_bit(w, k));
      else if (k <= 15) chk("R8 trailing zero", int'(sdata_out), 0);
      if (k < 16) chk("R4 oe during frame", int'(sdata_oe), 1);
      else begin
        chk("R8 release on 16th fall", int'(sdata_oe), 0);
        chk("R8 one done pulse", done_seen - d0, 1);
      end
      if (k == 13) chk("R6 still hold after 13th fall", int'(track_o), 0);
      sclk = 1'b1;
      settle();
      if (k < 13)  chk("R6 hold before window end", int'(track_o), 0);
      if (k == 13) chk("R6 track after next rise", int'(track_o), 1);
    end
    cs_n = 1'b1;
    settle();
    chk("R7 oe after release", int'(sdata_oe), 0);
    chk(exp_abort ? "R7 aborted flag" : "R9 aborted flag", int'(aborted), int'(exp_abort));
    chk(exp_abort ? "R7 no done pulse" : "R9 done pulse", done_seen - d0, int'(exp_done));
    chk("R7 track after frame", int'(track_o), 1);
    sample_in = w;
  endtask

  // {word[11:0], falls[4:0], expect abort, expect done}
  localparam int NVEC = 8;
  localparam logic [18:0] VEC [NVEC] = '{
    {12'hA5C, 5'd16, 1'b0, 1'b1},
    {12'hFFF, 5'd14, 1'b0, 1'b1},
    {12'h000, 5'd16, 1'b0, 1'b1},
    {12'h3C7, 5'd5,  1'b1, 1'b0},
    {12'h801, 5'd0,  1'b1, 1'b0},
    {12'h7FE, 5'd13, 1'b1, 1'b0},
    {12'h555, 5'd15, 1'b0, 1'b1},
    {12'hAAA, 5'd16, 1'b0, 1'b1}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 oe in reset", int'(sdata_oe), 0);
    chk("R1 data in reset", int'(sdata_out), 0);
    chk("R1 track in reset", int'(track_o), 1);
    chk("R1 aborted in reset", int'(aborted), 0);
    rst_n = 1'b1;
    settle();
    chk("R1 oe after reset", int'(sdata_oe), 0);
    chk("R1 done after reset", done_seen, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i][18:7], int'(VEC[i][6:2]), VEC[i][1], VEC[i][0]);
    end

    // R11: previous frame ended with abort; a new select fall clears it.
    run_frame(12'h123, 3, 1'b1, 1'b0);
    cs_n = 1'b0;
    settle();
    chk("R11 aborted cleared", int'(aborted), 0);
    cs_n = 1'b1;
    settle();

    // R10: serial clock toggles with select high.
    for (int j = 0; j < 3; j++) begin
      sclk = 1'b0;
      settle();
      chk("R10 idle oe", int'(sdata_oe), 0);
      chk("R10 idle data", int'(sdata_out), 0);
      sclk = 1'b1;
      settle();
    end
    run_frame(12'hC3A, 16, 1'b0, 1'b1);  // R10: frame restarts from slot 0

    // R5: input changes mid-frame must not alter output bits.
    scramble = 1'b1;
    run_frame(12'h9B4, 16, 1'b0, 1'b1);
    scramble = 1'b0;

    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!summary_done) begin
      summary_done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

endmodule